// File: doc/BRIEF.md
# Serial Flash Status-Register Command Slave

This block is the command front end of a serial NOR flash model that handles only the status-register commands. It watches an SPI bus (chip select, serial clock, serial data in) with its own system clock, gathers each 8-bit opcode and any data bytes, and acts on the command when chip select returns high on a whole byte boundary. It keeps a write-enable flag, a busy flag, six writable protection bits and a second 8-bit status register. During a read-status command it drives the selected register out on the serial data line.

A status write can be enabled in two ways. The first is the ordinary write-enable flag, which starts a busy period. The second is a one-shot volatile enable, which changes the bits at once without touching the write-enable flag or the busy flag. An external one-cycle completion pulse stands in for the end of any program, erase or status-write cycle. The pulse clears both busy and write enable. The serial pins pass through a synchronizer, so the SPI clock must be several times slower than the system clock. Both idle clock levels, low and high, are accepted.

Top module: `spi_sr_slave`

## Requirements
- R1: After reset both status registers read 00h, the write-enable flag, the busy flag and the volatile enable are cleared, and `spi_so_en` is low.
- R2: SI is sampled on SCK rising edges, MSB first. After opcode 05h the status register 1 byte is driven on SO, and after opcode 35h the status register 2 byte is driven, MSB first, each bit changing after an SCK falling edge. Status register 1 holds busy at bit 0, write enable at bit 1 and protection bits at bits 7:2. `spi_so_en` is low while CS is high, during the opcode byte and during any written bytes.
- R3: Opcode 06h sets the write-enable flag and opcode 04h clears it. A command acts only when CS rises after one or more complete bytes.
- R4: Opcode 01h while write enable is set (and busy is clear) copies bits 7:2 of the first data byte into status register 1 bits 7:2. A second data byte, if present, replaces status register 2. The write sets busy, and write enable stays set until completion. Without an enable, the 01h command changes nothing.
- R5: Opcode 50h arms a one-shot volatile enable. A following 01h then writes as in R4 without setting busy and without changing write enable. Any other completed command, including 01h and reads, disarms it.
- R6: A pulse on `op_done` clears busy and write enable in the next cycle.
- R7: While busy is set, all commands other than 05h and 35h have no effect.
- R8: A read is accepted while busy. While CS stays low the selected register repeats byte after byte, and its value is captured anew at each byte start, so a busy change shows up in the next byte.
- R9: If CS rises while a byte is incomplete, the frame has no effect at all, and this includes the volatile enable.
- R10: Frames that start with SCK idle high behave the same as frames that start with SCK idle low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | Serial clock from the host |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_si | input | 1 | Serial data from the host |
| op_done | input | 1 | One-cycle pulse marking the end of a program, erase or status-write cycle |
| spi_so | output | 1 | Serial data to the host |
| spi_so_en | output | 1 | Output enable for `spi_so`; low means high impedance |

## Verification
A wrong flag or register bit is not visible at once. It appears at the ports at the next read-status frame, within one byte of the readout, so the bench reads both registers back after commands and compares them with its own model. A stuck volatile enable or write-enable flag only shows up later, as a status write that should have been refused. For this reason the random sequences mix enables, disables, aborted frames and completion pulses before each readback. A stale readout snapshot is caught by a multi-byte read in which busy clears between bytes.

// File: rtl/spi_sr_pkg.sv
package spi_sr_pkg;

    localparam int BYTE_W  = 8;
    localparam int BIT_W   = $clog2(BYTE_W);
    localparam int PROT_W  = BYTE_W - 2;
    localparam int BCNT_W  = 2;

    typedef enum logic [BYTE_W-1:0] {
        OP_WRSR  = 8'h01,
        OP_WRDI  = 8'h04,
        OP_RDSR1 = 8'h05,
        OP_WREN  = 8'h06,
        OP_RDSR2 = 8'h35,
        OP_VWREN = 8'h50
    } op_e;

    typedef struct packed {
        logic [PROT_W-1:0] prot;
        logic              wel;
        logic              busy;
    } sr1_t;

    function automatic logic is_read(input logic [BYTE_W-1:0] op);
        return (op == OP_RDSR1) || (op == OP_RDSR2);
    endfunction

endpackage

// File: rtl/spi_sr_sync.sv
module spi_sr_sync #(
    parameter int          W       = 3,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stage[i] <= RST_VAL;
        end else begin
            stage[0] <= d;
            for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
        end
    end

    assign q = stage[STAGES-1];
endmodule

// File: rtl/spi_sr_rx.sv
module spi_sr_rx
    import spi_sr_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                frame_start,
    input  logic                in_frame,
    input  logic                sck_rise,
    input  logic                si,
    output logic [BYTE_W-1:0]   opcode,
    output logic [PROT_W-1:0]   wr_prot,
    output logic [BYTE_W-1:0]   wr_sr2,
    output logic [BCNT_W-1:0]   byte_cnt,
    output logic                aligned
);
    logic [BYTE_W-2:0] shreg;
    logic [BIT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] full_byte;

    assign full_byte = {shreg, si};
    assign aligned   = (bit_cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg    <= '0;
            bit_cnt  <= '0;
            byte_cnt <= '0;
            opcode   <= '0;
            wr_prot  <= '0;
            wr_sr2   <= '0;
        end else if (frame_start) begin
            bit_cnt  <= '0;
            byte_cnt <= '0;
        end else if (in_frame && sck_rise) begin
            shreg   <= full_byte[BYTE_W-2:0];
            bit_cnt <= bit_cnt + 1'b1;
            if (bit_cnt == BIT_W'(BYTE_W-1)) begin
                case (byte_cnt)
                    2'd0:    opcode  <= full_byte;
                    2'd1:    wr_prot <= full_byte[BYTE_W-1:2];
                    2'd2:    wr_sr2  <= full_byte;
                    default: ;
                endcase
                if (byte_cnt != '1) byte_cnt <= byte_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/spi_sr_regs.sv
module spi_sr_regs
    import spi_sr_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                exec,
    input  logic [BYTE_W-1:0]   opcode,
    input  logic [BCNT_W-1:0]   nbytes,
    input  logic [PROT_W-1:0]   wr_prot,
    input  logic [BYTE_W-1:0]   wr_sr2,
    input  logic                op_done,
    output sr1_t                sr1,
    output logic [BYTE_W-1:0]   sr2
);
    logic vol_arm;
    logic accept;
    logic wr_ok;

    assign accept = exec && (!sr1.busy || is_read(opcode));
    assign wr_ok  = (nbytes >= 2'd2) && (vol_arm || sr1.wel);

    always_ff @(posedge clk) begin
        if (rst) begin
            sr1     <= '0;
            sr2     <= '0;
            vol_arm <= 1'b0;
        end else begin
            if (accept) begin
                vol_arm <= 1'b0;
                case (opcode)
                    OP_WREN:  sr1.wel <= 1'b1;
                    OP_WRDI:  sr1.wel <= 1'b0;
                    OP_VWREN: vol_arm <= 1'b1;
                    OP_WRSR: begin
                        if (wr_ok) begin
                            sr1.prot <= wr_prot;
                            if (nbytes == 2'd3) sr2 <= wr_sr2;
                            if (!vol_arm) sr1.busy <= 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
            if (op_done) begin
                sr1.busy <= 1'b0;
                sr1.wel  <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/spi_sr_tx.sv
module spi_sr_tx
    import spi_sr_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                frame_start,
    input  logic                in_frame,
    input  logic                sck_fall,
    input  logic                rd_active,
    input  logic                rd_sel,
    input  logic [BYTE_W-1:0]   sr1_bits,
    input  logic [BYTE_W-1:0]   sr2_bits,
    output logic                so,
    output logic                so_en
);
    logic [BIT_W-1:0]  idx;
    logic [BYTE_W-2:0] snap;
    logic              drive;
    logic [BYTE_W-1:0] cur;

    assign cur   = rd_sel ? sr2_bits : sr1_bits;
    assign so_en = drive && in_frame;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx   <= '0;
            snap  <= '0;
            drive <= 1'b0;
            so    <= 1'b0;
        end else if (frame_start || !in_frame) begin
            idx   <= '0;
            drive <= 1'b0;
        end else if (rd_active && sck_fall) begin
            drive <= 1'b1;
            idx   <= idx + 1'b1;
            if (idx == '0) begin
                snap <= cur[BYTE_W-2:0];
                so   <= cur[BYTE_W-1];
            end else begin
                so   <= snap[BIT_W'(BYTE_W-1) - idx];
            end
        end
    end
endmodule

// File: rtl/spi_sr_slave.sv
module spi_sr_slave
    import spi_sr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic spi_sck,
    input  logic spi_cs_n,
    input  logic spi_si,
    input  logic op_done,
    output logic spi_so,
    output logic spi_so_en
);
    logic [2:0]          pins_s;
    logic                cs_s, sck_s, si_s;
    logic                cs_d, sck_d;
    logic                sck_rise, sck_fall, frame_start, frame_end, in_frame;
    logic [BYTE_W-1:0]   opcode;
    logic [PROT_W-1:0]   wr_prot;
    logic [BYTE_W-1:0]   wr_sr2;
    logic [BCNT_W-1:0]   byte_cnt;
    logic                aligned;
    logic                exec;
    logic                rd_active;
    sr1_t                sr1;
    logic [BYTE_W-1:0]   sr2;

    spi_sr_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({spi_cs_n, spi_sck, spi_si}),
        .q   (pins_s)
    );

    assign {cs_s, sck_s, si_s} = pins_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_d  <= 1'b1;
            sck_d <= 1'b0;
        end else begin
            cs_d  <= cs_s;
            sck_d <= sck_s;
        end
    end

    assign sck_rise    = sck_s & ~sck_d;
    assign sck_fall    = ~sck_s & sck_d;
    assign frame_start = cs_d & ~cs_s;
    assign frame_end   = ~cs_d & cs_s;
    assign in_frame    = ~cs_s;
    assign exec        = frame_end && aligned && (byte_cnt != '0);
    assign rd_active   = (byte_cnt != '0) && is_read(opcode);

    spi_sr_rx u_rx (
        .clk         (clk),
        .rst         (rst),
        .frame_start (frame_start),
        .in_frame    (in_frame),
        .sck_rise    (sck_rise),
        .si          (si_s),
        .opcode      (opcode),
        .wr_prot     (wr_prot),
        .wr_sr2      (wr_sr2),
        .byte_cnt    (byte_cnt),
        .aligned     (aligned)
    );

    spi_sr_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .exec    (exec),
        .opcode  (opcode),
        .nbytes  (byte_cnt),
        .wr_prot (wr_prot),
        .wr_sr2  (wr_sr2),
        .op_done (op_done),
        .sr1     (sr1),
        .sr2     (sr2)
    );

    spi_sr_tx u_tx (
        .clk         (clk),
        .rst         (rst),
        .frame_start (frame_start),
        .in_frame    (in_frame),
        .sck_fall    (sck_fall),
        .rd_active   (rd_active),
        .rd_sel      (opcode == OP_RDSR2),
        .sr1_bits    (sr1),
        .sr2_bits    (sr2),
        .so          (spi_so),
        .so_en       (spi_so_en)
    );
endmodule

// File: rtl/spi_sr_checker.sv
module spi_sr_checker (
    input logic       clk,
    input logic       rst,
    input logic       cs_sync,
    input logic [1:0] byte_cnt,
    input logic       so_en,
    input logic       op_done,
    input logic       exec,
    input logic [7:0] sr1
);
    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (sr1[1:0] == 2'b00)); // R1

    AST_SO_OFF_IDLE: assert property (@(posedge clk) disable iff (rst)
        cs_sync |-> !so_en); // R2

    AST_SO_OFF_OPCODE: assert property (@(posedge clk) disable iff (rst)
        (!cs_sync && byte_cnt == 2'd0) |-> !so_en); // R2

    AST_BUSY_NEEDS_CMD: assert property (@(posedge clk) disable iff (rst)
        !exec |=> !$rose(sr1[0])); // R4

    AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        op_done |=> (sr1[1:0] == 2'b00)); // R6

    AST_BUSY_NO_WEL_SET: assert property (@(posedge clk) disable iff (rst)
        sr1[0] |=> !$rose(sr1[1])); // R7

    AST_BUSY_PROT_HELD: assert property (@(posedge clk) disable iff (rst)
        sr1[0] |=> $stable(sr1[7:2])); // R7
endmodule

bind spi_sr_slave spi_sr_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .cs_sync  (cs_s),
    .byte_cnt (byte_cnt),
    .so_en    (spi_so_en),
    .op_done  (op_done),
    .exec     (exec),
    .sr1      (sr1)
);

// File: tb/sim_spi_sr_slave.sv
module sim_spi_sr_slave;
    localparam int CLK_PERIOD = 10;
    localparam int H          = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic spi_sck = 1'b0, spi_cs_n = 1'b1, spi_si = 1'b0, op_done = 1'b0;
    logic spi_so, spi_so_en;

    spi_sr_slave u0 (
        .clk(clk), .rst(rst), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
        .spi_si(spi_si), .op_done(op_done), .spi_so(spi_so), .spi_so_en(spi_so_en)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int  n_chk = 0, n_bad = 0;
    bit  done = 1'b0;

    logic [5:0] m_prot = '0;
    logic [7:0] m_sr2  = '0;
    bit m_busy = 0, m_wel = 0, m_arm = 0;

    logic [7:0] tx [4];
    logic [7:0] rx [4];
    bit so_leak;

    function automatic logic [7:0] exp_sr1();
        return {m_prot, m_wel, m_busy};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // one frame: ntx bytes from tx[], extra partial bits, then nrx bytes into rx[]
    task automatic xfer(input int ntx, input int nrx, input int extra, input bit m3);
        so_leak = 1'b0;
        spi_sck = m3;
        wait_clk(H);
        spi_cs_n = 1'b0;
        wait_clk(H);
        for (int i = 0; i < ntx; i++) begin
            for (int b = 7; b >= 0; b--) begin
                spi_sck = 1'b0; spi_si = tx[i][b];
                wait_clk(H);
                if (spi_so_en) so_leak = 1'b1;
                spi_sck = 1'b1;
                wait_clk(H);
            end
        end
        for (int k = 0; k < extra; k++) begin
            spi_sck = 1'b0; spi_si = 1'b1;
            wait_clk(H);
            spi_sck = 1'b1;
            wait_clk(H);
        end
        for (int i = 0; i < nrx; i++) begin
            for (int b = 7; b >= 0; b--) begin
                spi_sck = 1'b0; spi_si = 1'b0;
                wait_clk(H);
                rx[i][b] = spi_so_en ? spi_so : 1'bx;
                spi_sck = 1'b1;
                wait_clk(H);
            end
        end
        spi_sck = m3;
        wait_clk(H);
        spi_cs_n = 1'b1;
        wait_clk(2*H);
    endtask

    task automatic model_cmd(input logic [7:0] op, input int nfull, input logic [7:0] d1,
                             input logic [7:0] d2);
        bit rd;
        rd = (op == 8'h05) || (op == 8'h35);
        if (nfull == 0) return;
        if (m_busy && !rd) return;
        case (op)
            8'h06: m_wel = 1;
            8'h04: m_wel = 0;
            8'h50: begin m_arm = 1; return; end
            8'h01: if (nfull >= 2 && (m_arm || m_wel)) begin
                m_prot = d1[7:2];
                if (nfull >= 3) m_sr2 = d2;
                if (!m_arm) m_busy = 1;
            end
            default: ;
        endcase
        m_arm = 0;
    endtask

    task automatic cmd(input logic [7:0] op, input int nfull, input logic [7:0] d1,
                       input logic [7:0] d2, input int extra, input bit m3);
        tx[0] = op; tx[1] = d1; tx[2] = d2;
        xfer(nfull, 0, extra, m3);
        chk("R2 so_en during written bytes", {31'd0, so_leak}, 32'd0);
        if (extra == 0) model_cmd(op, nfull, d1, d2);
    endtask

    task automatic read_chk(input string req, input bit sel, input bit m3);
        logic [7:0] e;
        tx[0] = sel ? 8'h35 : 8'h05;
        e = sel ? m_sr2 : exp_sr1();
        xfer(1, 1, 0, m3);
        chk({req, " readback"}, {24'd0, rx[0]}, {24'd0, e});
        chk("R2 so_en off after CS high", {31'd0, spi_so_en}, 32'd0);
        model_cmd(tx[0], 1, 8'h00, 8'h00);
    endtask

    task automatic pulse_done();
        @(negedge clk); op_done = 1'b1;
        @(negedge clk); op_done = 1'b0;
        m_busy = 0; m_wel = 0;
        wait_clk(2);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        wait_clk(5);
        rst = 1'b0;
        wait_clk(5);

        // R1: reset state
        chk("R1 so_en after reset", {31'd0, spi_so_en}, 32'd0);
        read_chk("R1 sr1", 1'b0, 1'b0);
        read_chk("R1 sr2", 1'b1, 1'b0);

        // R3: enable / disable
        cmd(8'h06, 1, 0, 0, 0, 0);
        read_chk("R3 wren sets wel", 1'b0, 1'b0);
        cmd(8'h04, 1, 0, 0, 0, 0);
        read_chk("R3 wrdi clears wel", 1'b0, 1'b0);

        // R4: status write refused without enable
        cmd(8'h01, 3, 8'hA5, 8'h3C, 0, 0);
        read_chk("R4 refused write sr1", 1'b0, 1'b0);
        read_chk("R4 refused write sr2", 1'b1, 1'b0);

        // R4: enabled write starts busy
        cmd(8'h06, 1, 0, 0, 0, 0);
        cmd(8'h01, 3, 8'hA4, 8'h3C, 0, 0);
        read_chk("R4 R8 write sr1 busy", 1'b0, 1'b0);
        read_chk("R4 write sr2", 1'b1, 1'b0);

        // R7: disable ignored while busy
        cmd(8'h04, 1, 0, 0, 0, 0);
        read_chk("R7 wrdi ignored while busy", 1'b0, 1'b0);

        // R8 + R6: completion between repeated read bytes
        tx[0] = 8'h05;
        fork
            xfer(1, 2, 0, 0);
            begin wait_clk(26*H); @(negedge clk); op_done = 1'b1; @(negedge clk); op_done = 1'b0; end
        join
        chk("R8 first byte busy", {24'd0, rx[0]}, 32'h0000_00A7);
        chk("R8 R6 second byte recaptured", {24'd0, rx[1]}, 32'h0000_00A4);
        m_busy = 0; m_wel = 0; m_arm = 0;

        // R5: volatile path, one data byte
        cmd(8'h50, 1, 0, 0, 0, 0);
        cmd(8'h01, 2, 8'h18, 8'hFF, 0, 0);
        read_chk("R5 volatile write no busy", 1'b0, 1'b0);
        read_chk("R4 single byte leaves sr2", 1'b1, 1'b0);

        // R5: disarmed by another command
        cmd(8'h50, 1, 0, 0, 0, 0);
        cmd(8'h04, 1, 0, 0, 0, 0);
        cmd(8'h01, 2, 8'h5C, 8'h00, 0, 0);
        read_chk("R5 arm cleared by other cmd", 1'b0, 1'b0);

        // R9: aborted frames
        cmd(8'h06, 1, 0, 0, 1, 0);
        read_chk("R9 aborted wren", 1'b0, 1'b0);
        cmd(8'h50, 1, 0, 0, 3, 0);
        cmd(8'h01, 2, 8'hFC, 8'h00, 0, 0);
        read_chk("R9 aborted arm", 1'b0, 1'b0);
        cmd(8'h06, 1, 0, 0, 0, 0);
        cmd(8'h01, 2, 8'hE0, 8'h00, 5, 0);
        read_chk("R9 aborted write", 1'b0, 1'b0);

        // R10: idle-high clock frames
        cmd(8'h04, 1, 0, 0, 0, 1);
        read_chk("R10 mode3 wrdi", 1'b0, 1'b1);
        cmd(8'h06, 1, 0, 0, 0, 1);
        read_chk("R10 mode3 wren", 1'b0, 1'b1);
        cmd(8'h01, 3, 8'h6C, 8'h81, 0, 1);
        read_chk("R10 mode3 sr2", 1'b1, 1'b1);
        pulse_done();
        read_chk("R6 done clears", 1'b0, 1'b0);

        // random mix
        for (int it = 0; it < 70; it++) begin
            logic [7:0] op;
            int sel, nf, ex;
            sel = $urandom_range(0, 7);
            case (sel)
                0: op = 8'h01; 1: op = 8'h04; 2: op = 8'h06; 3: op = 8'h50;
                4: op = 8'h01; 5: op = 8'h05; 6: op = 8'h35;
                default: op = 8'($urandom_range(0, 255));
            endcase
            if (op == 8'h05 || op == 8'h35) begin
                read_chk("R2 R8 random read", op == 8'h35, 1'($urandom_range(0, 1)));
            end else begin
                nf = $urandom_range(1, 3);
                ex = ($urandom_range(0, 9) == 0) ? $urandom_range(1, 7) : 0;
                cmd(op, nf, 8'($urandom_range(0, 255)), 8'($urandom_range(0, 255)),
                    ex, 1'($urandom_range(0, 1)));
            end
            if ($urandom_range(0, 3) == 0) pulse_done();
            if ($urandom_range(0, 2) == 0) begin
                read_chk("R3 R4 R5 R7 random sr1", 1'b0, 1'b0);
                read_chk("R4 random sr2", 1'b1, 1'b0);
            end
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule